// File: doc/BRIEF.md
# Cross-Clock Mailbox Register

This block carries a single data word from a sender on clock domain A to a receiver on clock domain B without passing through the queue that normally links the two ports. The sender writes the word with its mailbox-select input high; the block stores it and, a couple of receiver clocks later, pulls an active-low mail-waiting flag down. The receiver then reads with its own mailbox-select input high. Its output register loads the stored word. A couple of sender clocks after that read, the flag returns high.

The receiver's output register is shared with the queue path. A read with mailbox-select low loads the queue's output word, which comes in on `fifoOut`, in place of the mailbox word. The stored word is kept after a read, so it can be read again until the next accepted write replaces it. While mail is waiting, further sender writes are dropped, so an unread word is never overwritten. The receiver's configured bus width sets how many low-order bits are stored, and the bits above that width are stored as zero.

Top module: `mailbox_bridge`

## Requirements
- R1: While `rstN` is low, `mailFullN` is 1 and `bDataOut` is all zeros.
- R2: A sender write (`aEn`=1, `aMailSel`=1) accepted while no mail is pending stores the word and drives `mailFullN` low. The flag is still high right after the sender edge, and it is low no later than the third following `clkB` rising edge.
- R3: After a receiver mailbox read (`bRead`=1, `bMailSel`=1) of pending mail, `mailFullN` stays low at least until the next `clkA` edge. It is high again no later than the fourth following `clkA` rising edge.
- R4: A sender mailbox write that arrives while mail is pending is ignored. The stored word is unchanged, and a later receiver read returns the first word.
- R5: A sender access with `aMailSel`=0 changes neither the stored word nor `mailFullN`.
- R6: On a `clkB` edge with `bRead`=1, `bDataOut` loads the stored mailbox word if `bMailSel`=1, and loads `fifoOut` if `bMailSel`=0.
- R7: On a `clkB` edge with `bRead`=0, `bDataOut` holds its value.
- R8: The stored word stays valid after a read. A second mailbox read returns the same word. A read when no mail is pending leaves `mailFullN` high.
- R9: `bWidth` encodes the receiver width: 2'b00 means 36 bits, 2'b01 means 18 bits, and 2'b10 or 2'b11 means 9 bits. When the width is 18 bits, stored bits 35:18 are zero. When it is 9 bits, stored bits 35:9 are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkA | input | 1 | Sender clock |
| clkB | input | 1 | Receiver clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| aEn | input | 1 | Sender access enable |
| aMailSel | input | 1 | Sender access targets the mailbox |
| aDataIn | input | 36 | Sender write data |
| bRead | input | 1 | Receiver read enable |
| bMailSel | input | 1 | Receiver read targets the mailbox |
| bWidth | input | 2 | Receiver bus width code |
| fifoOut | input | 36 | Queue output word for the read multiplexer |
| bDataOut | output | 36 | Receiver output register |
| mailFullN | output | 1 | Active-low mail-waiting flag |

## Verification
If the sender's write toggle and the acknowledge it synchronises fall out of step, the flag shows it at the port. The flag either stays high after a write or stays low after a read, and this is visible within four cycles of the slower clock. A wrong accept decision shows up at the next receiver read: that read returns the overwriting word in place of the first one. Errors in the width mask or in the output multiplexer appear on `bDataOut` at the receiver edge that performs the read.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef struct packed {
    logic loadMail;   // sender domain: accepted mailbox write
    logic readMail;   // receiver domain: mailbox read
    logic readFifo;   // receiver domain: queue read
  } mboxStrobe_t;

  localparam logic [1:0] WIDTH_FULL = 2'b00;
  localparam logic [1:0] WIDTH_HALF = 2'b01;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clkA,
  input  logic        clkB,
  input  logic        rstN,
  input  logic        aEn,
  input  logic        aMailSel,
  input  logic        bRead,
  input  logic        bMailSel,
  output mboxStrobe_t strobe,
  output logic        busyA,
  output logic        pendB,
  output logic        mailFullN
);
  logic reqTog;
  logic ackTogB;
  logic reqSyncB;
  logic ackSyncA;

  // sender side: toggle on every accepted write, busy until the ack returns
  assign busyA           = reqTog ^ ackSyncA;
  assign strobe.loadMail = aEn & aMailSel & ~busyA;

  always_ff @(posedge clkA or negedge rstN)
    if (!rstN) reqTog <= 1'b0;
    else       reqTog <= reqTog ^ strobe.loadMail;

  mbox_sync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk (clkB), .rstN (rstN), .d (reqTog), .q (reqSyncB)
  );

  // receiver side: pending while the seen request differs from its own ack
  assign pendB           = reqSyncB ^ ackTogB;
  assign strobe.readMail = bRead & bMailSel;
  assign strobe.readFifo = bRead & ~bMailSel;

  always_ff @(posedge clkB or negedge rstN)
    if (!rstN) ackTogB <= 1'b0;
    else       ackTogB <= ackTogB ^ (strobe.readMail & pendB);

  mbox_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk (clkA), .rstN (rstN), .d (ackTogB), .q (ackSyncA)
  );

  // low edge comes from the receiver flop, high edge from the sender flop
  assign mailFullN = ~(reqSyncB ^ ackSyncA);
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int HALF_W = 18,
  parameter int BYTE_W = 9
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  mboxStrobe_t       strobe,
  input  logic [1:0]        bWidth,
  input  logic [DATA_W-1:0] aDataIn,
  input  logic [DATA_W-1:0] fifoOut,
  output logic [DATA_W-1:0] mailWord,
  output logic [DATA_W-1:0] bDataOut
);
  localparam logic [DATA_W-1:0] MASK_FULL = '1;
  localparam logic [DATA_W-1:0] MASK_HALF = MASK_FULL >> (DATA_W - HALF_W);
  localparam logic [DATA_W-1:0] MASK_BYTE = MASK_FULL >> (DATA_W - BYTE_W);

  logic [DATA_W-1:0] widthMask;

  always_comb begin
    unique case (bWidth)
      WIDTH_FULL: widthMask = MASK_FULL;
      WIDTH_HALF: widthMask = MASK_HALF;
      default:    widthMask = MASK_BYTE;
    endcase
  end

  always_ff @(posedge clkA or negedge rstN)
    if (!rstN)                mailWord <= '0;
    else if (strobe.loadMail) mailWord <= aDataIn & widthMask;

  // mailWord is stable whenever it is read as pending mail
  always_ff @(posedge clkB or negedge rstN)
    if (!rstN)                bDataOut <= '0;
    else if (strobe.readMail) bDataOut <= mailWord;
    else if (strobe.readFifo) bDataOut <= fifoOut;
endmodule

// File: rtl/mailbox_bridge.sv
module mailbox_bridge
  import mbox_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int HALF_W      = 18,
  parameter int BYTE_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic              aEn,
  input  logic              aMailSel,
  input  logic [DATA_W-1:0] aDataIn,
  input  logic              bRead,
  input  logic              bMailSel,
  input  logic [1:0]        bWidth,
  input  logic [DATA_W-1:0] fifoOut,
  output logic [DATA_W-1:0] bDataOut,
  output logic              mailFullN
);
  mboxStrobe_t       strobe;
  logic              busyA;
  logic              pendB;
  logic [DATA_W-1:0] mailWord;

  mbox_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clkA (clkA), .clkB (clkB), .rstN (rstN),
    .aEn (aEn), .aMailSel (aMailSel),
    .bRead (bRead), .bMailSel (bMailSel),
    .strobe (strobe), .busyA (busyA), .pendB (pendB),
    .mailFullN (mailFullN)
  );

  mbox_datapath #(.DATA_W(DATA_W), .HALF_W(HALF_W), .BYTE_W(BYTE_W)) u_dp (
    .clkA (clkA), .clkB (clkB), .rstN (rstN),
    .strobe (strobe), .bWidth (bWidth),
    .aDataIn (aDataIn), .fifoOut (fifoOut),
    .mailWord (mailWord), .bDataOut (bDataOut)
  );
endmodule

// File: rtl/mailbox_bridge_chk.sv
module mailbox_bridge_chk
  import mbox_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int BYTE_W = 9
) (
  input logic              clkA,
  input logic              clkB,
  input logic              rstN,
  input logic              aEn,
  input logic              aMailSel,
  input logic              bRead,
  input logic              bMailSel,
  input logic [1:0]        bWidth,
  input logic [DATA_W-1:0] fifoOut,
  input logic [DATA_W-1:0] bDataOut,
  input logic              mailFullN,
  input mboxStrobe_t       strobe,
  input logic              busyA,
  input logic              pendB,
  input logic [DATA_W-1:0] mailWord
);
  p_reset_state_r1: assert property (@(posedge clkB)
    !rstN |-> (mailFullN && bDataOut == '0));

  p_write_marks_busy_r2: assert property (@(posedge clkA) disable iff (!rstN)
    strobe.loadMail |=> busyA);

  p_read_clears_pend_r3: assert property (@(posedge clkB) disable iff (!rstN)
    (strobe.readMail && pendB) |=> !pendB);

  p_no_overwrite_r4: assert property (@(posedge clkA) disable iff (!rstN)
    (aEn && aMailSel && busyA) |=> $stable(mailWord));

  p_fifo_access_ignored_r5: assert property (@(posedge clkA) disable iff (!rstN)
    !(aEn && aMailSel) |=> $stable(mailWord));

  p_mail_to_bus_r6: assert property (@(posedge clkB) disable iff (!rstN)
    (bRead && bMailSel && pendB) |=> bDataOut == $past(mailWord));

  p_fifo_to_bus_r6: assert property (@(posedge clkB) disable iff (!rstN)
    (bRead && !bMailSel) |=> bDataOut == $past(fifoOut));

  p_hold_bus_r7: assert property (@(posedge clkB) disable iff (!rstN)
    !bRead |=> $stable(bDataOut));

  p_byte_mask_r9: assert property (@(posedge clkA) disable iff (!rstN)
    (strobe.loadMail && bWidth[1]) |=> (mailWord >> BYTE_W) == '0);
endmodule

bind mailbox_bridge mailbox_bridge_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clkA (clkA), .clkB (clkB), .rstN (rstN),
  .aEn (aEn), .aMailSel (aMailSel),
  .bRead (bRead), .bMailSel (bMailSel), .bWidth (bWidth),
  .fifoOut (fifoOut), .bDataOut (bDataOut), .mailFullN (mailFullN),
  .strobe (strobe), .busyA (busyA), .pendB (pendB), .mailWord (mailWord)
);

// File: tb/mailbox_bridge_tb.sv
module mailbox_bridge_tb;
  logic        clkA = 1'b0;
  logic        clkB = 1'b0;
  logic        rstN = 1'b0;
  logic        aEn = 1'b0;
  logic        aMailSel = 1'b0;
  logic [35:0] aDataIn = '0;
  logic        bRead = 1'b0;
  logic        bMailSel = 1'b0;
  logic [1:0]  bWidth = 2'b00;
  logic [35:0] fifoOut = '0;
  logic [35:0] bDataOut;
  logic        mailFullN;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clkA = ~clkA;   // 50 MHz sender clock
  always #7  clkB = ~clkB;   // unrelated receiver clock

  mailbox_bridge u_dut (
    .clkA (clkA), .clkB (clkB), .rstN (rstN),
    .aEn (aEn), .aMailSel (aMailSel), .aDataIn (aDataIn),
    .bRead (bRead), .bMailSel (bMailSel), .bWidth (bWidth),
    .fifoOut (fifoOut), .bDataOut (bDataOut), .mailFullN (mailFullN)
  );

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic aWrite(input logic [35:0] d, input logic mail);
    @(negedge clkA);
    aEn = 1'b1; aMailSel = mail; aDataIn = d;
    @(negedge clkA);
    aEn = 1'b0; aMailSel = 1'b0;
  endtask

  task automatic bReadOp(input logic mail);
    @(negedge clkB);
    bRead = 1'b1; bMailSel = mail;
    @(negedge clkB);
    bRead = 1'b0; bMailSel = 1'b0;
  endtask

  task automatic waitB(input int n);
    for (int i = 0; i < n; i++) @(negedge clkB);
  endtask

  task automatic waitA(input int n);
    for (int i = 0; i < n; i++) @(negedge clkA);
  endtask

  task automatic t_reset;
    #3;
    check(mailFullN === 1'b1, "R1 flag in reset", {35'd0, mailFullN}, 36'd1);
    check(bDataOut === 36'd0, "R1 bus in reset", bDataOut, 36'd0);
    waitA(3);
    rstN = 1'b1;
    waitA(2);
  endtask

  task automatic t_send_receive;
    aWrite(36'h9_ABCD_1234, 1'b1);
    check(mailFullN === 1'b1, "R2 flag not yet low", {35'd0, mailFullN}, 36'd1);
    waitB(3);
    check(mailFullN === 1'b0, "R2 flag low", {35'd0, mailFullN}, 36'd0);
    bReadOp(1'b1);
    check(bDataOut === 36'h9_ABCD_1234, "R6 mail on bus", bDataOut, 36'h9_ABCD_1234);
    check(mailFullN === 1'b0, "R3 flag still low after read", {35'd0, mailFullN}, 36'd0);
    waitA(4);
    check(mailFullN === 1'b1, "R3 flag released", {35'd0, mailFullN}, 36'd1);
  endtask

  task automatic t_reread;
    fifoOut = 36'h0_0000_0055;
    bReadOp(1'b0);
    bReadOp(1'b1);
    check(bDataOut === 36'h9_ABCD_1234, "R8 reread same word", bDataOut, 36'h9_ABCD_1234);
    waitA(4);
    check(mailFullN === 1'b1, "R8 flag stays high", {35'd0, mailFullN}, 36'd1);
  endtask

  task automatic t_no_overwrite;
    aWrite(36'h1_1111_1111, 1'b1);
    waitB(3);
    aWrite(36'h2_2222_2222, 1'b1);
    waitB(2);
    check(mailFullN === 1'b0, "R4 flag still low", {35'd0, mailFullN}, 36'd0);
    bReadOp(1'b1);
    check(bDataOut === 36'h1_1111_1111, "R4 first word kept", bDataOut, 36'h1_1111_1111);
    waitA(4);
  endtask

  task automatic t_fifo_side;
    aWrite(36'h7_7777_7777, 1'b0);
    waitB(4);
    check(mailFullN === 1'b1, "R5 flag untouched", {35'd0, mailFullN}, 36'd1);
    bReadOp(1'b1);
    check(bDataOut === 36'h1_1111_1111, "R5 word untouched", bDataOut, 36'h1_1111_1111);
    fifoOut = 36'hC_0FFE_E123;
    bReadOp(1'b0);
    check(bDataOut === 36'hC_0FFE_E123, "R6 queue word on bus", bDataOut, 36'hC_0FFE_E123);
  endtask

  task automatic t_hold;
    fifoOut = 36'h3_3333_3333;
    waitB(5);
    check(bDataOut === 36'hC_0FFE_E123, "R7 bus holds", bDataOut, 36'hC_0FFE_E123);
  endtask

  task automatic t_widths;
    bWidth = 2'b01;
    aWrite(36'hF_FFFF_FFFF, 1'b1);
    waitB(3);
    bReadOp(1'b1);
    check(bDataOut === 36'h0_0003_FFFF, "R9 half width", bDataOut, 36'h0_0003_FFFF);
    waitA(4);
    bWidth = 2'b10;
    aWrite(36'hA_5A5A_5A5A, 1'b1);
    waitB(3);
    bReadOp(1'b1);
    check(bDataOut === 36'h0_0000_005A, "R9 byte width", bDataOut, 36'h0_0000_005A);
    waitA(4);
    bWidth = 2'b11;
    aWrite(36'hF_FFFF_FFFF, 1'b1);
    waitB(3);
    bReadOp(1'b1);
    check(bDataOut === 36'h0_0000_01FF, "R9 code 11 is byte width", bDataOut, 36'h0_0000_01FF);
    waitA(4);
    check(mailFullN === 1'b1, "R3 flag high after last read", {35'd0, mailFullN}, 36'd1);
  endtask

  initial begin
    t_reset;
    t_send_receive;
    t_reread;
    t_no_overwrite;
    t_fifo_side;
    t_hold;
    t_widths;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule